// File: doc/BRIEF.md
# Omega Network Packet Switch

This block is a self-routing multistage interconnect for N ports, N being a power of two. Each port may offer one message per cycle: a valid bit, an n-bit destination number and a payload. The message passes through n = log2(N) columns of 2x2 switching cells. A perfect-shuffle wiring sits in front of every column. Each column reads one bit of the destination and uses it as the steering decision for that cell. After the last column, a message sits on the output port whose index equals its destination.

The network is blocking. Two messages can arrive at one cell and both ask for the same cell output. In that case the message on the upper cell input goes on and the lower one is dropped. The block does not buffer or retry a dropped message. It reports the loss on the blocked flag of the input port the message came from. A parameter selects a purely combinational datapath or one register stage on every output, including the blocked flags.

Top module: `omega_net`

## Requirements
- R1: The block has N = 2^n ports, and each destination field is n bits wide. A message that is not blocked leaves on the output port whose index equals its destination, and its payload is unchanged.
- R2: Column k (k = 0 first) reads destination bit n-1-k. A 0 selects the upper cell output and a 1 selects the lower one. Each column is preceded by a perfect shuffle that moves line p to the line given by rotating p left by one bit. As a result, input ports i and i+N/2 meet in the same first-column cell, with input i on the upper side.
- R3: When both inputs of a cell are valid and ask for the same output, the upper input goes on and the lower message is dropped. For example, if inputs i and i+N/2 (i < N/2) are both valid and their destinations share the most significant bit, input i+N/2 is reported blocked.
- R4: An input with in_valid low produces no output, never raises a blocked flag and never contends. An idle network drives every out_valid and in_blocked bit low.
- R5: Every valid input is either delivered to exactly one output or flagged blocked, never both. The number of valid outputs plus the number of blocked flags equals the number of valid inputs.
- R6: The identity mapping and every cyclic shift (destination = (i + c) mod N) are delivered with no blocking. A set of messages that all share one destination delivers exactly one of them.
- R7: With OUT_REG = 0, the outputs and blocked flags follow the inputs in the same cycle. With OUT_REG = 1, they appear one clock edge later, and the blocked flags stay aligned with the outputs.
- R8: With OUT_REG = 1, out_valid and in_blocked are all low while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the optional output register) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-port message present |
| in_dst | input | N x n | Per-port destination number |
| in_data | input | N x PAY_W | Per-port payload |
| out_valid | output | N | Per-port message delivered |
| out_data | output | N x PAY_W | Per-port delivered payload |
| in_blocked | output | N | Per-input flag: this port's message was dropped |

## Verification
Delivery and blocking can happen in the same cycle: one message reaches its port while another, offered at the same moment, loses a cell to it. The bench provokes this in three ways. It places directed pairs on inputs i and i+N/2 whose destinations share the top bit. It sends all inputs to one destination. It also sends randomly masked, random and permuted destination sets with a fixed seed. Each cycle is judged against a bench path model. The model walks every message column by column through rotate-left shuffles, and where a cell has a collision the odd (lower) line loses. The model gives the expected valid, payload and blocked vectors for both the combinational and the registered variant, including the one-cycle lag of the registered variant.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle: line p moves to p rotated left by one bit within lg bits.
  function automatic int unsigned shuffle_pos(input int unsigned p, input int unsigned lg);
    int unsigned mask;
    mask = (32'd1 << lg) - 32'd1;
    return ((p << 1) | (p >> (lg - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int DW  = 3,
  parameter int PW  = 8,
  parameter int SEL = 2
) (
  input  logic          u_v,
  input  logic [DW-1:0] u_src,
  input  logic [DW-1:0] u_dst,
  input  logic [PW-1:0] u_dat,
  input  logic          l_v,
  input  logic [DW-1:0] l_src,
  input  logic [DW-1:0] l_dst,
  input  logic [PW-1:0] l_dat,
  output logic          t_v,
  output logic [DW-1:0] t_src,
  output logic [DW-1:0] t_dst,
  output logic [PW-1:0] t_dat,
  output logic          b_v,
  output logic [DW-1:0] b_src,
  output logic [DW-1:0] b_dst,
  output logic [PW-1:0] b_dat,
  output logic          drop_v,
  output logic [DW-1:0] drop_src
);

  logic u_bit, l_bit;

  assign u_bit = u_dst[SEL];
  assign l_bit = l_dst[SEL];

  // Upper input has priority on both cell outputs.
  always_comb begin
    t_v = 1'b0; t_src = '0; t_dst = '0; t_dat = '0;
    b_v = 1'b0; b_src = '0; b_dst = '0; b_dat = '0;
    if (u_v && !u_bit) begin
      t_v = 1'b1; t_src = u_src; t_dst = u_dst; t_dat = u_dat;
    end else if (l_v && !l_bit) begin
      t_v = 1'b1; t_src = l_src; t_dst = l_dst; t_dat = l_dat;
    end
    if (u_v && u_bit) begin
      b_v = 1'b1; b_src = u_src; b_dst = u_dst; b_dat = u_dat;
    end else if (l_v && l_bit) begin
      b_v = 1'b1; b_src = l_src; b_dst = l_dst; b_dat = l_dat;
    end
  end

  assign drop_v   = u_v & l_v & (u_bit == l_bit);
  assign drop_src = l_src;

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N  = 8,
  parameter int DW = 3,
  parameter int PW = 8,
  parameter int K  = 0
) (
  input  logic [N-1:0]         v_i,
  input  logic [N-1:0][DW-1:0] src_i,
  input  logic [N-1:0][DW-1:0] dst_i,
  input  logic [N-1:0][PW-1:0] dat_i,
  output logic [N-1:0]         v_o,
  output logic [N-1:0][DW-1:0] src_o,
  output logic [N-1:0][DW-1:0] dst_o,
  output logic [N-1:0][PW-1:0] dat_o,
  output logic [N-1:0]         blk_o
);

  localparam int HALF = N / 2;
  localparam int SEL  = DW - 1 - K;

  logic [N-1:0]            sh_v;
  logic [N-1:0][DW-1:0]    sh_src, sh_dst;
  logic [N-1:0][PW-1:0]    sh_dat;
  logic [HALF-1:0]         drop_v;
  logic [HALF-1:0][DW-1:0] drop_src;

  for (genvar p = 0; p < N; p++) begin : g_shuffle
    localparam int Q = int'(omega_pkg::shuffle_pos(p, DW));
    assign sh_v[Q]   = v_i[p];
    assign sh_src[Q] = src_i[p];
    assign sh_dst[Q] = dst_i[p];
    assign sh_dat[Q] = dat_i[p];
  end

  for (genvar s = 0; s < HALF; s++) begin : g_cell
    omega_switch #(.DW(DW), .PW(PW), .SEL(SEL)) u_cell (
      .u_v (sh_v[2*s]),   .u_src(sh_src[2*s]),   .u_dst(sh_dst[2*s]),   .u_dat(sh_dat[2*s]),
      .l_v (sh_v[2*s+1]), .l_src(sh_src[2*s+1]), .l_dst(sh_dst[2*s+1]), .l_dat(sh_dat[2*s+1]),
      .t_v (v_o[2*s]),    .t_src(src_o[2*s]),    .t_dst(dst_o[2*s]),    .t_dat(dat_o[2*s]),
      .b_v (v_o[2*s+1]),  .b_src(src_o[2*s+1]),  .b_dst(dst_o[2*s+1]),  .b_dat(dat_o[2*s+1]),
      .drop_v(drop_v[s]), .drop_src(drop_src[s])
    );
  end

  // Decode dropped source ids into a per-input flag vector.
  always_comb begin
    blk_o = '0;
    for (int s = 0; s < HALF; s++) begin
      if (drop_v[s]) blk_o[drop_src[s]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N_PORTS = 8,
  parameter int PAY_W   = 8,
  parameter bit OUT_REG = 1'b0,
  localparam int DST_W  = $clog2(N_PORTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_PORTS-1:0]               in_valid,
  input  logic [N_PORTS-1:0][DST_W-1:0]    in_dst,
  input  logic [N_PORTS-1:0][PAY_W-1:0]    in_data,
  output logic [N_PORTS-1:0]               out_valid,
  output logic [N_PORTS-1:0][PAY_W-1:0]    out_data,
  output logic [N_PORTS-1:0]               in_blocked
);

  localparam int LG = DST_W;

  logic [LG:0][N_PORTS-1:0]             ln_v;
  logic [LG:0][N_PORTS-1:0][DST_W-1:0]  ln_src, ln_dst;
  logic [LG:0][N_PORTS-1:0][PAY_W-1:0]  ln_dat;
  logic [LG-1:0][N_PORTS-1:0]           st_blk;
  logic [N_PORTS-1:0]                   blk_nx;

  assign ln_v[0]   = in_valid;
  assign ln_dst[0] = in_dst;
  assign ln_dat[0] = in_data;
  for (genvar i = 0; i < N_PORTS; i++) begin : g_src
    assign ln_src[0][i] = DST_W'(i);
  end

  for (genvar k = 0; k < LG; k++) begin : g_stage
    omega_stage #(.N(N_PORTS), .DW(DST_W), .PW(PAY_W), .K(k)) u_stage (
      .v_i  (ln_v[k]),   .src_i(ln_src[k]),   .dst_i(ln_dst[k]),   .dat_i(ln_dat[k]),
      .v_o  (ln_v[k+1]), .src_o(ln_src[k+1]), .dst_o(ln_dst[k+1]), .dat_o(ln_dat[k+1]),
      .blk_o(st_blk[k])
    );
  end

  always_comb begin
    blk_nx = '0;
    for (int k = 0; k < LG; k++) blk_nx = blk_nx | st_blk[k];
  end

  logic unused_tail;
  assign unused_tail = ^{ln_src[LG], ln_dst[LG]};

  if (OUT_REG) begin : g_oreg
    logic [N_PORTS-1:0]            v_q, b_q;
    logic [N_PORTS-1:0][PAY_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        b_q <= '0;
      end else begin
        v_q <= ln_v[LG];
        b_q <= blk_nx;
      end
    end

    // Payload lanes load only when a message lands on them.
    for (genvar o = 0; o < N_PORTS; o++) begin : g_dreg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          d_q[o] <= '0;
        else if (ln_v[LG][o]) d_q[o] <= ln_dat[LG][o];
      end
    end

    assign out_valid  = v_q;
    assign out_data   = d_q;
    assign in_blocked = b_q;
  end else begin : g_ocomb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign out_valid  = ln_v[LG];
    assign out_data   = ln_dat[LG];
    assign in_blocked = blk_nx;
  end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int N_PORTS = 8,
  parameter int PAY_W   = 8,
  parameter bit OUT_REG = 1'b0,
  localparam int DST_W  = $clog2(N_PORTS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_PORTS-1:0]            in_valid,
  input logic [N_PORTS-1:0][DST_W-1:0] in_dst,
  input logic [N_PORTS-1:0][PAY_W-1:0] in_data,
  input logic [N_PORTS-1:0]            out_valid,
  input logic [N_PORTS-1:0][PAY_W-1:0] out_data,
  input logic [N_PORTS-1:0]            in_blocked
);

  localparam int HALF = N_PORTS / 2;

  logic [N_PORTS-1:0]            sv;
  logic [N_PORTS-1:0][DST_W-1:0] sd;
  logic [N_PORTS-1:0][PAY_W-1:0] sp;

  // Inputs as seen by the current outputs (one cycle back when registered).
  if (OUT_REG) begin : g_seen_q
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sv <= '0; sd <= '0; sp <= '0;
      end else begin
        sv <= in_valid; sd <= in_dst; sp <= in_data;
      end
    end
  end else begin : g_seen_c
    assign sv = in_valid;
    assign sd = in_dst;
    assign sp = in_data;
  end

  logic [N_PORTS-1:0] match;
  logic               dup;

  always_comb begin
    match = '0;
    dup   = 1'b0;
    for (int o = 0; o < N_PORTS; o++)
      for (int i = 0; i < N_PORTS; i++)
        if (sv[i] && !in_blocked[i] && sd[i] == DST_W'(o) && sp[i] == out_data[o])
          match[o] = 1'b1;
    for (int i = 0; i < N_PORTS; i++)
      for (int j = i + 1; j < N_PORTS; j++)
        if (sv[i] && sv[j] && sd[i] == sd[j]) dup = 1'b1;
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_route
    p_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> match[o]);
  end

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    p_lower_loses_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sv[i] && sv[i+HALF] && sd[i][DST_W-1] == sd[i+HALF][DST_W-1]) |-> in_blocked[i+HALF]);
  end

  p_conserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_valid) + $countones(in_blocked)) == $countones(sv));

  p_blk_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blocked & ~sv) == '0);

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sv == '0) |-> (out_valid == '0 && in_blocked == '0));

  p_dup_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dup |-> (in_blocked != '0));

endmodule

bind omega_net omega_net_chk #(.N_PORTS(N_PORTS), .PAY_W(PAY_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .in_blocked(in_blocked)
);

// File: tb/omega_net_tb.sv
module omega_net_tb;

  localparam int N  = 8;
  localparam int LG = 3;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]         in_valid;
  logic [N-1:0][LG-1:0] in_dst;
  logic [N-1:0][W-1:0]  in_data;
  logic [N-1:0]         ov_c, ob_c, ov_r, ob_r;
  logic [N-1:0][W-1:0]  od_c, od_r;

  always #10 clk = ~clk;

  omega_net #(.N_PORTS(N), .PAY_W(W), .OUT_REG(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
    .out_valid(ov_c), .out_data(od_c), .in_blocked(ob_c));

  omega_net #(.N_PORTS(N), .PAY_W(W), .OUT_REG(1'b1)) u_dut_reg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
    .out_valid(ov_r), .out_data(od_r), .in_blocked(ob_r));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [N-1:0]        ev, eb, pv, pb;
  logic [N-1:0][W-1:0] ed, pd;

  function automatic int rotl(input int p);
    return ((p << 1) | (p >> (LG - 1))) & (N - 1);
  endfunction

  // Path model: follow each message through the columns, lower line loses.
  task automatic model();
    int  pos [N];
    int  np  [N];
    int  ln  [N];
    bit  alive [N];
    bit  kill  [N];
    for (int i = 0; i < N; i++) begin pos[i] = i; alive[i] = in_valid[i]; end
    for (int k = 0; k < LG; k++) begin
      for (int i = 0; i < N; i++) begin
        ln[i] = rotl(pos[i]);
        np[i] = (ln[i] & ~1) | int'(in_dst[i][LG-1-k]);
        kill[i] = 1'b0;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j && alive[i] && alive[j] && np[i] == np[j] && (ln[i] & 1) == 1)
            kill[i] = 1'b1;
      for (int i = 0; i < N; i++) begin
        pos[i] = np[i];
        if (kill[i]) alive[i] = 1'b0;
      end
    end
    ev = '0; eb = '0; ed = '0;
    for (int i = 0; i < N; i++) begin
      if (alive[i]) begin ev[pos[i]] = 1'b1; ed[pos[i]] = in_data[i]; end
      else if (in_valid[i]) eb[i] = 1'b1;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0][W-1:0] mask_d(input logic [N-1:0][W-1:0] d, input logic [N-1:0] v);
    logic [N-1:0][W-1:0] r;
    for (int o = 0; o < N; o++) r[o] = v[o] ? d[o] : '0;
    return r;
  endfunction

  // Inputs are already set at a falling edge.
  task automatic apply(input string req);
    model();
    #2;
    chk(req, "comb valid", 64'(ov_c), 64'(ev));
    chk(req, "comb blocked", 64'(ob_c), 64'(eb));
    chk(req, "comb data", 64'(mask_d(od_c, ev)), 64'(mask_d(ed, ev)));
    chk("R7", "reg holds previous valid", 64'(ov_r), 64'(pv));
    @(posedge clk); #2;
    chk(req, "reg valid", 64'(ov_r), 64'(ev));
    chk(req, "reg blocked", 64'(ob_r), 64'(eb));
    chk(req, "reg data", 64'(mask_d(od_r, ev)), 64'(mask_d(ed, ev)));
    chk("R7", "reg blocked aligned", 64'(ob_r), 64'(eb));
    pv = ev; pb = eb; pd = ed;
    @(negedge clk);
  endtask

  task automatic fill_data();
    for (int i = 0; i < N; i++) in_data[i] = W'($urandom);
  endtask

  int dlv;

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = '0; in_dst = '0; in_data = '0;
    pv = '0; pb = '0; pd = '0;
    @(negedge clk); @(negedge clk);
    chk("R8", "reset valid", 64'(ov_r), 64'd0);
    chk("R8", "reset blocked", 64'(ob_r), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: idle
    in_valid = '0; fill_data(); apply("R4");

    // R6 / R1: identity
    in_valid = '1; fill_data();
    for (int i = 0; i < N; i++) in_dst[i] = LG'(i);
    apply("R6");
    chk("R6", "identity no block", 64'(pb), 64'd0);

    // R6: cyclic shifts
    for (int c = 1; c < N; c++) begin
      in_valid = '1; fill_data();
      for (int i = 0; i < N; i++) in_dst[i] = LG'(i + c);
      apply("R6");
      chk("R6", "shift no block", 64'(pb), 64'd0);
    end

    // R3 / R2: inputs 1 and 5 share the first cell, same top bit
    in_valid = 8'b0010_0010; fill_data();
    in_dst[1] = 3'd0; in_dst[5] = 3'd1;
    apply("R3");
    chk("R3", "lower pair input blocked", 64'(pb), 64'h20);
    chk("R2", "upper pair input delivered at port 0", 64'(pv), 64'h01);

    // R2: different top bits in a shared cell both pass
    in_valid = 8'b0001_0001; fill_data();
    in_dst[0] = 3'd6; in_dst[4] = 3'd2;
    apply("R2");
    chk("R2", "split by top bit", 64'(pv), 64'h44);

    // R4: invalid input with colliding destination does not contend
    in_valid = 8'b0000_0010; fill_data();
    in_dst[1] = 3'd3; in_dst[5] = 3'd3;
    apply("R4");
    chk("R4", "no block from idle neighbour", 64'(pb), 64'd0);
    chk("R1", "single message at port 3", 64'(pv), 64'h08);

    // R6 / R5: all to one destination
    in_valid = '1; fill_data();
    for (int i = 0; i < N; i++) in_dst[i] = 3'd5;
    apply("R5");
    chk("R6", "hotspot delivers one", 64'($countones(pv)), 64'd1);
    chk("R5", "hotspot blocks rest", 64'($countones(pb)), 64'(N - 1));

    // Random: masked random destinations and random permutations
    for (int it = 0; it < 300; it++) begin
      in_valid = N'($urandom); fill_data();
      if (it % 2 == 0) begin
        for (int i = 0; i < N; i++) in_dst[i] = LG'(i);
        for (int i = N - 1; i > 0; i--) begin
          int j; logic [LG-1:0] t;
          j = int'($urandom % (i + 1));
          t = in_dst[i]; in_dst[i] = in_dst[j]; in_dst[j] = t;
        end
        apply("R1");
      end else begin
        for (int i = 0; i < N; i++) in_dst[i] = LG'($urandom);
        apply("R5");
      end
      dlv = $countones(pv) + $countones(pb);
      chk("R5", "conservation", 64'(dlv), 64'($countones(in_valid)));
    end

    in_valid = '0;
    apply("R4");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule